// File: doc/BRIEF.md
# Machine-Cycle Bus Strobe Generator

This block produces the two external-bus strobes of an 8051-style core: the address-latch pulse (`ale`, active high) and the program-fetch read strobe (`psen_n`, active low). It runs from the oscillator clock. A toggling phase flop halves the clock, so the timing never depends on the high or low time of the incoming oscillator. Six states of two phases each make one machine cycle of twelve oscillator periods. The current state and phase are exported so the surrounding bus logic can align its own transfers.

Four mode inputs set what one machine cycle looks like:

- Whether code comes from external memory.
- Whether the cycle is an external data transfer.
- Whether the cycle is a code-table read.
- An address-latch-suppress control bit, written through a one-bit write port.

The first three inputs and the stored control bit are sampled once per machine cycle, on its final clock. They govern the whole of the following machine cycle. A data transfer drops the second address-latch pulse of its machine cycle and both fetch strobes. When the suppress bit is set, the latch pulse is held at a steady high (flagged as a weak pull-up level) except in data-transfer and table-read cycles. The suppress bit is ignored while code runs from external memory.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst` is high (synchronous) and on the first clock after it falls, the outputs read `state_o`=0, `phase_o`=0, `ale`=1, `psen_n`=1 and `ale_weak`=0. Reset also clears the suppress bit to 0.
- R2: `phase_o` toggles on every clock. `state_o` advances by one only on a clock where `phase_o` was 1, and wraps from 5 to 0. One machine cycle is therefore 12 clocks.
- R3: In a machine cycle that is not a data transfer and has address-latch enabled, `ale` is 1 in states 0 and 3 (both phases) and 0 in every other state. This gives two pulses per machine cycle.
- R4: In a data-transfer machine cycle, the state-3 `ale` pulse is omitted and the state-0 pulse remains.
- R5: With external code and no data transfer, `psen_n` is 0 in states 2 and 5 and 1 in every other state.
- R6: In a data-transfer machine cycle, `psen_n` stays 1 for all 12 clocks, even with external code. This skips both fetch strobes.
- R7: With internal code, `psen_n` is 1 in every state.
- R8: With the suppress bit set, internal code, and neither a data transfer nor a table read, `ale` is held at 1 and `ale_weak` is 1 for the whole machine cycle.
- R9: With the suppress bit set, a data-transfer or table-read machine cycle pulses `ale` as in R3/R4 with `ale_weak`=0.
- R10: With external code, the suppress bit has no effect: `ale` pulses as in R3/R4 and `ale_weak`=0.
- R11: `ext_code`, `data_cyc`, `movc_cyc` and the suppress bit are sampled on the clock that ends state 5 phase 1. Changes to them inside a machine cycle do not alter that cycle. A clock with `cfg_we`=1 loads `cfg_d` into the suppress bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_code | input | 1 | Code is fetched from external program memory |
| data_cyc | input | 1 | Next machine cycle is an external data transfer |
| movc_cyc | input | 1 | Next machine cycle is a code-table read |
| cfg_we | input | 1 | Write strobe for the suppress bit |
| cfg_d | input | 1 | Value written to the suppress bit |
| ale | output | 1 | Address-latch pulse, active high |
| psen_n | output | 1 | Program-fetch read strobe, active low |
| ale_weak | output | 1 | `ale` is parked at the weak high level |
| state_o | output | 3 | Current state 0..5 within the machine cycle |
| phase_o | output | 1 | Current phase within the state (0 or 1) |

## Verification
The sequencer is the only source of timing. A wrong state or phase register would shift every `ale` and `psen_n` edge, and the bench would see the mismatch on the very next clock, through the exported state and phase. A wrongly latched mode shows up only at the next machine-cycle boundary. It then appears within at most 12 clocks, as a missing or extra state-3 latch pulse, fetch strobes in the wrong place, or a wrong `ale_weak` level. A suppress bit that does not clear on reset or load on a write appears only in a machine cycle with internal code and no data or table access. The scenarios include such cycles for that reason.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  // Mode of one machine cycle, frozen at the cycle boundary
  typedef struct packed {
    logic ext;   // code from external memory
    logic dat;   // external data transfer
    logic mvc;   // code-table read
    logic aoff;  // address-latch suppress bit
  } cyc_mode_t;

  localparam cyc_mode_t MODE_RESET = '{ext: 1'b0, dat: 1'b0, mvc: 1'b0, aoff: 1'b0};

endpackage

// File: rtl/mc_seq.sv
module mc_seq #(
  parameter int NUM_STATES = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [$clog2(NUM_STATES)-1:0] st,
  output logic                          ph,
  output logic [$clog2(NUM_STATES)-1:0] st_nx,
  output logic                          ph_nx,
  output logic                          wrap
);
  localparam int ST_W = $clog2(NUM_STATES);
  localparam logic [ST_W-1:0] LAST = ST_W'(NUM_STATES - 1);

  // Divide-by-two phase, state moves on the second phase
  always_comb begin
    ph_nx = ~ph;
    wrap  = ph && (st == LAST);
    if (!ph)
      st_nx = st;
    else if (wrap)
      st_nx = '0;
    else
      st_nx = st + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
      ph <= 1'b0;
    end else begin
      st <= st_nx;
      ph <= ph_nx;
    end
  end
endmodule

// File: rtl/mc_mode.sv
module mc_mode
  import bsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wrap,
  input  cyc_mode_t mode_in,
  output cyc_mode_t mode_q,
  output cyc_mode_t mode_nx
);
  // Mode for the next registered cycle
  always_comb mode_nx = wrap ? mode_in : mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RESET;
    else     mode_q <= mode_nx;
  end
endmodule

// File: rtl/mc_strobe.sv
module mc_strobe
  import bsg_pkg::*;
#(
  parameter int NUM_STATES = 6,
  parameter int ALE_ST_A   = 0,
  parameter int ALE_ST_B   = 3,
  parameter int FETCH_ST_A = 2,
  parameter int FETCH_ST_B = 5
) (
  input  logic [$clog2(NUM_STATES)-1:0] st,
  input  cyc_mode_t                     mode,
  output logic                          ale,
  output logic                          psen_n,
  output logic                          ale_weak
);
  localparam int ST_W = $clog2(NUM_STATES);
  localparam logic [ST_W-1:0] SA = ST_W'(ALE_ST_A);
  localparam logic [ST_W-1:0] SB = ST_W'(ALE_ST_B);
  localparam logic [ST_W-1:0] FA = ST_W'(FETCH_ST_A);
  localparam logic [ST_W-1:0] FB = ST_W'(FETCH_ST_B);

  logic pulse, enable, fetch;

  always_comb begin
    // second latch pulse dropped in a data transfer
    pulse  = (st == SA) || ((st == SB) && !mode.dat);
    // suppress bit overridden by external code or an external access
    enable = !mode.aoff || mode.ext || mode.dat || mode.mvc;
    // both fetch strobes dropped in a data transfer
    fetch  = mode.ext && !mode.dat && ((st == FA) || (st == FB));
    ale      = enable ? pulse : 1'b1;
    ale_weak = !enable;
    psen_n   = !fetch;
  end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int NUM_STATES = 6,
  parameter int ALE_ST_A   = 0,
  parameter int ALE_ST_B   = 3,
  parameter int FETCH_ST_A = 2,
  parameter int FETCH_ST_B = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ext_code,
  input  logic                          data_cyc,
  input  logic                          movc_cyc,
  input  logic                          cfg_we,
  input  logic                          cfg_d,
  output logic                          ale,
  output logic                          psen_n,
  output logic                          ale_weak,
  output logic [$clog2(NUM_STATES)-1:0] state_o,
  output logic                          phase_o
);
  localparam int ST_W = $clog2(NUM_STATES);

  logic [ST_W-1:0] st, st_nx;
  logic            ph, ph_nx, wrap;
  logic            aoff_q;
  cyc_mode_t       mode_in, mode_q, mode_nx;
  logic            ale_d, psen_n_d, weak_d;

  mc_seq #(.NUM_STATES(NUM_STATES)) u_seq (
    .clk(clk), .rst(rst), .st(st), .ph(ph),
    .st_nx(st_nx), .ph_nx(ph_nx), .wrap(wrap)
  );

  // suppress bit
  always_ff @(posedge clk) begin
    if (rst)         aoff_q <= 1'b0;
    else if (cfg_we) aoff_q <= cfg_d;
  end

  always_comb begin
    mode_in.ext  = ext_code;
    mode_in.dat  = data_cyc;
    mode_in.mvc  = movc_cyc;
    mode_in.aoff = aoff_q;
  end

  mc_mode u_mode (
    .clk(clk), .rst(rst), .wrap(wrap),
    .mode_in(mode_in), .mode_q(mode_q), .mode_nx(mode_nx)
  );

  // Decode from next state so the strobe registers line up with state_o
  mc_strobe #(
    .NUM_STATES(NUM_STATES), .ALE_ST_A(ALE_ST_A), .ALE_ST_B(ALE_ST_B),
    .FETCH_ST_A(FETCH_ST_A), .FETCH_ST_B(FETCH_ST_B)
  ) u_strobe (
    .st(st_nx), .mode(mode_nx),
    .ale(ale_d), .psen_n(psen_n_d), .ale_weak(weak_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ale      <= 1'b1;
      psen_n   <= 1'b1;
      ale_weak <= 1'b0;
    end else begin
      ale      <= ale_d;
      psen_n   <= psen_n_d;
      ale_weak <= weak_d;
    end
  end

  assign state_o = st;
  assign phase_o = ph;

  // mode_q only feeds itself through mc_mode; keep it observed
  logic unused_ok;
  assign unused_ok = ^{mode_q, ph_nx};
endmodule

// File: rtl/bsg_checker.sv
module bsg_checker #(
  parameter int NUM_STATES = 6,
  parameter int FETCH_ST_A = 2,
  parameter int FETCH_ST_B = 5
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          ale,
  input logic                          psen_n,
  input logic                          ale_weak,
  input logic [$clog2(NUM_STATES)-1:0] state_o,
  input logic                          phase_o
);
  localparam int ST_W = $clog2(NUM_STATES);

  // R2: phase alternates on every clock
  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase_o != $past(phase_o)));

  // R2: state holds across the first phase
  assert_state_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !phase_o |=> $stable(state_o));

  // R2: state stays inside 0..NUM_STATES-1
  assert_state_range_R2: assert property (@(posedge clk) disable iff (rst)
    state_o <= ST_W'(NUM_STATES - 1));

  // R5: fetch strobe only in its two states
  assert_fetch_states_R5: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (state_o == ST_W'(FETCH_ST_A) || state_o == ST_W'(FETCH_ST_B)));

  // R3: the two strobes never overlap
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !ale);

  // R8: parked level is high
  assert_weak_high_R8: assert property (@(posedge clk) disable iff (rst)
    ale_weak |-> ale);

  // R11: parked flag changes only at a machine-cycle start
  assert_weak_per_cycle_R11: assert property (@(posedge clk) disable iff (rst)
    !(state_o == '0 && !phase_o) |-> $stable(ale_weak));
endmodule

bind bus_strobe_gen bsg_checker #(
  .NUM_STATES(NUM_STATES), .FETCH_ST_A(FETCH_ST_A), .FETCH_ST_B(FETCH_ST_B)
) u_bsg_checker (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .ale_weak(ale_weak),
  .state_o(state_o), .phase_o(phase_o)
);

// File: tb/test_bus_strobe_gen.sv
module test_bus_strobe_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_code = 1'b0, data_cyc = 1'b0, movc_cyc = 1'b0;
  logic cfg_we = 1'b0, cfg_d = 1'b0;
  logic ale, psen_n, ale_weak, phase_o;
  logic [2:0] state_o;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  bus_strobe_gen i_bus_strobe_gen (
    .clk(clk), .rst(rst), .ext_code(ext_code), .data_cyc(data_cyc),
    .movc_cyc(movc_cyc), .cfg_we(cfg_we), .cfg_d(cfg_d),
    .ale(ale), .psen_n(psen_n), .ale_weak(ale_weak),
    .state_o(state_o), .phase_o(phase_o)
  );

  // Behavioural reference: position in the machine cycle and frozen mode
  int  m_pos = 0;             // 0..11 clocks into the machine cycle
  bit  m_ext, m_dat, m_mvc, m_off;
  bit  m_bit;                 // suppress bit

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_ext = 0; m_dat = 0; m_mvc = 0; m_off = 0; m_bit = 0;
    end else begin
      if (m_pos == 11) begin
        m_ext = ext_code; m_dat = data_cyc; m_mvc = movc_cyc; m_off = m_bit;
      end
      m_pos = (m_pos + 1) % 12;
      if (cfg_we) m_bit = cfg_d;
    end
  end

  task automatic chk(string what, int act, int exp, string rq);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (pos %0d)", rq, what, act, exp, m_pos);
    end
  endtask

  task automatic compare();
    int  s;
    bit  en, e_ale, e_psn;
    s     = m_pos / 2;
    en    = !m_off || m_ext || m_dat || m_mvc;
    e_ale = en ? ((s == 0) || (s == 3 && !m_dat)) : 1'b1;
    e_psn = !(m_ext && !m_dat && (s == 2 || s == 5));
    chk("state_o", int'(state_o), s, "R2");
    chk("phase_o", int'(phase_o), m_pos % 2, "R2");
    chk("ale", int'(ale), int'(e_ale), tag);
    chk("psen_n", int'(psen_n), int'(e_psn), tag);
    chk("ale_weak", int'(ale_weak), int'(!en), tag);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic write_bit(bit v);
    @(negedge clk);
    compare();
    cfg_we = 1'b1; cfg_d = v;
    @(negedge clk);
    compare();
    cfg_we = 1'b0;
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL R2 watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset values held during reset and on the first clock after it
    repeat (3) @(negedge clk);
    chk("ale reset", int'(ale), 1, "R1");
    chk("psen_n reset", int'(psen_n), 1, "R1");
    chk("ale_weak reset", int'(ale_weak), 0, "R1");
    chk("state reset", int'(state_o), 0, "R1");
    rst = 1'b0;
    run(24);                                      // R1 bit cleared, R3/R7 internal
    tag = "R3"; run(24);
    tag = "R7"; run(12);
    tag = "R5"; ext_code = 1'b1; run(36);         // external code fetches
    tag = "R6"; data_cyc = 1'b1; run(24);         // both fetch strobes skipped
    tag = "R4"; ext_code = 1'b0; run(24);         // second latch pulse skipped
    data_cyc = 1'b0;
    tag = "R8"; write_bit(1'b1); run(34);         // parked high
    tag = "R9"; movc_cyc = 1'b1; run(24);
    movc_cyc = 1'b0; data_cyc = 1'b1; run(24);
    data_cyc = 1'b0;
    tag = "R10"; ext_code = 1'b1; run(36);        // suppress ignored
    ext_code = 1'b0;
    tag = "R11"; run(17);                         // mid-cycle toggles
    data_cyc = 1'b1; run(3); data_cyc = 1'b0; run(16);
    write_bit(1'b0); run(30);
    // reset mid-cycle clears suppress bit and state
    tag = "R1"; write_bit(1'b1); run(5);
    rst = 1'b1; run(2); rst = 1'b0; run(24);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule